// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Fault Flags

This block is a single-byte SPI engine that can act either as the clock-driving master or as a selected slave. Software controls it through three byte-wide registers. The control register holds an enable bit, a master-select bit and a 3-bit clock-rate code. The status register holds four event flags. The data register is written to load a byte and read to fetch the last byte received. In master mode, writing the data register launches a transfer. The serial clock is a divided copy of the peripheral clock. Data moves most significant bit first, the clock idles low, and data is sampled on the rising edge.

The sequencer has four states. ST_IDLE waits for work. ST_M_LO is the low half of a master clock period. ST_M_HI is the high half. ST_S_BUSY is an active slave byte.

The transitions are:
- ST_IDLE to ST_M_LO (master launch): a data write while the block is enabled, in master mode, with a valid rate code and no fault.
- ST_IDLE to ST_S_BUSY (slave start): the first rising serial clock seen while the block is enabled, in slave mode and selected.
- ST_M_LO to ST_M_HI: the rate tick.
- ST_M_HI to ST_M_LO: the rate tick on bits 7..1.
- ST_M_HI to ST_IDLE: the rate tick on the eighth bit.
- ST_S_BUSY to ST_IDLE: the eighth falling slave clock, or release of select (abort).
- Any state to ST_IDLE: clearing enable, or a mode fault.

The slave inputs pass through a two-stage synchronizer before edge detection. Control layout: bit 6 enable, bit 4 master, bits 2:0 rate code, other bits read zero. Status layout: bit 7 done, bit 6 collision, bit 5 slave abort, bit 4 mode fault.

Top module: `spi_fault_ctrl`

## Requirements
- R1: After reset the control register reads 8'h14, the status register and data register read 8'h00, and `sclk_o` is low.
- R2: For rate codes 1 to 6, the divisor is 2^(code+1) and each clock half lasts 2^code cycles. A master byte sets the done flag 16·2^code cycles after the edge that accepts the data write.
- R3: With rate code 0 or 7, a data write in master mode launches nothing: `sclk_o` never rises and the done flag stays 0.
- R4: A master byte drives `mosi_o` MSB first, changing after falling edges. It samples `miso_i` at each rising edge, and the data register then returns the byte sampled.
- R5: The done flag (status bit 7) is 0 from the launch of a byte until it completes, and 1 after completion.
- R6: A data write while a byte is in flight sets the collision flag (bit 6). The written byte is dropped and the byte in flight completes unchanged.
- R7: A status read followed by a data register access (read or write) clears the done, collision and mode-fault flags. A data access with no status read before it leaves them set.
- R8: When the block is enabled in master mode and `sel_n_i` is low, the mode-fault flag (bit 4) sets, the master bit clears, and any byte in flight is abandoned with `sclk_o` low.
- R9: In slave mode, while `sel_n_i` is low, the block shifts its loaded byte out on `miso_o` MSB first and captures `mosi_i` on rising `sclk_i`. It sets the done flag after the eighth falling `sclk_i`, and the data register then returns the captured byte.
- R10: Releasing `sel_n_i` after at least one slave clock rise and before the byte ends sets the slave-abort flag (bit 5). The clearing sequence leaves it set; clearing the enable bit clears it.
- R11: Status bits 3 to 0 always read 0.
- R12: Clearing the enable bit abandons a master byte: `sclk_o` stays low from the next cycle and the done flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the clearing sequence on a status read) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| sclk_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in for master mode |
| sclk_i | input | 1 | Serial clock from an external master |
| mosi_i | input | 1 | Serial data in for slave mode |
| sel_n_i | input | 1 | Active-low select from an external master |
| miso_o | output | 1 | Serial data out in slave mode |

## Verification
Master bytes are swept over every valid rate code. A run of bit patterns is also sent at the fastest rate. Cycle counts to completion are compared with 16·2^code, which tells a wrong divisor from a wrong half-period. Each transmitted byte differs from the byte returned by the bench's slave model, so a swapped bit order or a shift in the wrong direction shows up in both directions. A set of slave bytes driven from the bench checks reception and the presented byte apart from the master path. The two invalid codes, a collision write, a fault on select, an early select release and a disable in mid-byte each exercise one flag path. In each, the bench separates the flags that the clearing sequence clears from the one flag it must not touch.

// File: rtl/spi_fault_pkg.sv
package spi_fault_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_M_LO   = 2'd1,
        ST_M_HI   = 2'd2,
        ST_S_BUSY = 2'd3
    } xfer_state_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    localparam int CTRL_EN_BIT = 6;
    localparam int CTRL_MS_BIT = 4;
    localparam logic [7:0] CTRL_RESET = 8'h14;

    localparam int STAT_DONE_BIT  = 7;
    localparam int STAT_COLL_BIT  = 6;
    localparam int STAT_ABORT_BIT = 5;
    localparam int STAT_FAULT_BIT = 4;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick,
    output logic              rate_ok
);

    localparam int CNT_W = (1 << RATE_W) - 1;

    logic [RATE_W-1:0] rate_lat;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  half_m1;

    always_comb begin
        half_m1 = (CNT_W'(1) << rate_lat) - CNT_W'(1);
        tick    = run && (cnt == half_m1);
        rate_ok = (rate != '0) && (rate != '1);
    end

    // rate is frozen for the whole byte once the engine runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            rate_lat <= '0;
        end else begin
            if (!run) rate_lat <= rate;
            if (!run || tick) cnt <= '0;
            else              cnt <= cnt + CNT_W'(1);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= half_m1)); // R2

endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic stat_rd,
    input  logic data_acc,
    input  logic xfer_start,
    input  logic xfer_done,
    input  logic collide,
    input  logic fault,
    input  logic slave_abort,
    output logic done_flag,
    output logic coll_flag,
    output logic fault_flag,
    output logic abort_flag
);

    logic armed;
    logic clr_seq;

    assign clr_seq = armed && data_acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            done_flag  <= 1'b0;
            coll_flag  <= 1'b0;
            fault_flag <= 1'b0;
            abort_flag <= 1'b0;
        end else begin
            if (stat_rd)       armed <= 1'b1;
            else if (data_acc) armed <= 1'b0;

            if (xfer_start)     done_flag <= 1'b0;
            else if (xfer_done) done_flag <= 1'b1;
            else if (clr_seq)   done_flag <= 1'b0;

            if (collide)      coll_flag <= 1'b1;
            else if (clr_seq) coll_flag <= 1'b0;

            if (fault)        fault_flag <= 1'b1;
            else if (clr_seq) fault_flag <= 1'b0;

            // only a disable releases the abort flag
            if (!enable)          abort_flag <= 1'b0;
            else if (slave_abort) abort_flag <= 1'b1;
        end
    end

    AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && $past(abort_flag)) |-> abort_flag); // R10

endmodule

// File: rtl/spi_fault_ctrl.sv
module spi_fault_ctrl
    import spi_fault_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int RATE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              sel_n_i,
    output logic              miso_o
);

    localparam int BIT_W = $clog2(DATA_W);
    localparam int MSB   = DATA_W - 1;

    xfer_state_e state_q, state_d;

    logic              en_q, ms_q;
    logic [RATE_W-1:0] rate_q;
    logic [DATA_W-1:0] shreg, rx_q, ctrl_word, stat_word;
    logic [BIT_W-1:0]  bitcnt;
    logic              smp;
    logic              s_ss_n, s_sclk, s_mosi, s_sclk_prev;
    logic              s_rise, s_fall;
    logic              tick, rate_ok, run;
    logic              done_flag, coll_flag, fault_flag, abort_flag;
    logic              ctrl_wr, data_wr, data_rd, stat_rd;
    logic              mode_fault, m_start, s_start, m_done, s_done, s_abort;
    logic              collide, shift_now, m_sample, s_sample, load_now, last_bit;

    // slave-side inputs cross into the peripheral clock domain
    spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sel_n_i, sclk_i, mosi_i}),
        .q    ({s_ss_n, s_sclk, s_mosi})
    );

    assign run = (state_q == ST_M_LO) || (state_q == ST_M_HI);

    spi_rate_div #(.RATE_W(RATE_W)) i_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .rate   (rate_q),
        .tick   (tick),
        .rate_ok(rate_ok)
    );

    always_comb begin
        ctrl_wr    = reg_wr && (reg_sel == SEL_CTRL);
        data_wr    = reg_wr && (reg_sel == SEL_DATA);
        data_rd    = reg_rd && (reg_sel == SEL_DATA);
        stat_rd    = reg_rd && (reg_sel == SEL_STAT);
        s_rise     = s_sclk && !s_sclk_prev;
        s_fall     = !s_sclk && s_sclk_prev;
        last_bit   = (bitcnt == BIT_W'(DATA_W - 1));
        mode_fault = en_q && ms_q && !s_ss_n;
        m_start    = (state_q == ST_IDLE) && en_q && ms_q && !mode_fault
                     && data_wr && rate_ok;
        s_start    = (state_q == ST_IDLE) && en_q && !ms_q && !s_ss_n && s_rise;
        m_done     = (state_q == ST_M_HI) && tick && last_bit && en_q && !mode_fault;
        s_done     = (state_q == ST_S_BUSY) && s_fall && last_bit && !s_ss_n && en_q;
        s_abort    = (state_q == ST_S_BUSY) && s_ss_n && en_q;
        collide    = data_wr && (state_q != ST_IDLE);
        shift_now  = ((state_q == ST_M_HI) && tick)
                     || ((state_q == ST_S_BUSY) && s_fall && !s_ss_n);
        m_sample   = (state_q == ST_M_LO) && tick;
        s_sample   = s_start || ((state_q == ST_S_BUSY) && s_rise);
        load_now   = (state_q == ST_IDLE) && data_wr && (m_start || !ms_q);
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (m_start)      state_d = ST_M_LO;
                else if (s_start) state_d = ST_S_BUSY;
            end
            ST_M_LO: begin
                if (tick) state_d = ST_M_HI;
            end
            ST_M_HI: begin
                if (tick) state_d = last_bit ? ST_IDLE : ST_M_LO;
            end
            ST_S_BUSY: begin
                if (s_ss_n || (s_fall && last_bit)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (!en_q || mode_fault) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // control register; a fault overrides a write of the master bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= CTRL_RESET[CTRL_EN_BIT];
            ms_q   <= CTRL_RESET[CTRL_MS_BIT];
            rate_q <= CTRL_RESET[RATE_W-1:0];
        end else begin
            if (ctrl_wr) begin
                en_q   <= reg_wdata[CTRL_EN_BIT];
                ms_q   <= reg_wdata[CTRL_MS_BIT];
                rate_q <= reg_wdata[RATE_W-1:0];
            end
            if (mode_fault) ms_q <= 1'b0;
        end
    end

    // shift engine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg       <= '0;
            rx_q        <= '0;
            smp         <= 1'b0;
            bitcnt      <= '0;
            s_sclk_prev <= 1'b0;
        end else begin
            s_sclk_prev <= s_sclk;
            if (load_now)       shreg <= reg_wdata;
            else if (shift_now) shreg <= {shreg[MSB-1:0], smp};
            if (m_sample)      smp <= miso_i;
            else if (s_sample) smp <= s_mosi;
            if (state_q == ST_IDLE) bitcnt <= '0;
            else if (shift_now)     bitcnt <= bitcnt + BIT_W'(1);
            if (m_done || s_done) rx_q <= {shreg[MSB-1:0], smp};
        end
    end

    spi_flag_unit i_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (en_q),
        .stat_rd    (stat_rd),
        .data_acc   (data_wr || data_rd),
        .xfer_start (m_start || s_start),
        .xfer_done  (m_done || s_done),
        .collide    (collide),
        .fault      (mode_fault),
        .slave_abort(s_abort),
        .done_flag  (done_flag),
        .coll_flag  (coll_flag),
        .fault_flag (fault_flag),
        .abort_flag (abort_flag)
    );

    // outputs
    always_comb begin
        sclk_o = (state_q == ST_M_HI);
        mosi_o = (en_q && ms_q) ? shreg[MSB] : 1'b0;
        miso_o = (en_q && !ms_q && !s_ss_n) ? shreg[MSB] : 1'b0;

        ctrl_word              = '0;
        ctrl_word[CTRL_EN_BIT] = en_q;
        ctrl_word[CTRL_MS_BIT] = ms_q;
        ctrl_word[RATE_W-1:0]  = rate_q;

        stat_word                 = '0;
        stat_word[STAT_DONE_BIT]  = done_flag;
        stat_word[STAT_COLL_BIT]  = coll_flag;
        stat_word[STAT_ABORT_BIT] = abort_flag;
        stat_word[STAT_FAULT_BIT] = fault_flag;

        case (reg_sel)
            SEL_CTRL: reg_rdata = ctrl_word;
            SEL_STAT: reg_rdata = stat_word;
            SEL_DATA: reg_rdata = rx_q;
            default:  reg_rdata = '0;
        endcase
    end

    AST_NO_BAD_RATE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !rate_ok) |=> (state_q != ST_M_LO)); // R3

    AST_DONE_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !done_flag); // R5

    AST_COLL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_flag) |-> ($past(state_q) != ST_IDLE)); // R6

    AST_FAULT_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_flag) |-> !ms_q); // R8

    AST_SCLK_LOW_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !sclk_o); // R12

endmodule

// File: tb/test_spi_fault_ctrl.sv
module test_spi_fault_ctrl;
    import spi_fault_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = SEL_CTRL;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sclk_o, mosi_o, miso_i, miso_o;
    logic       sclk_i = 1'b0;
    logic       mosi_i = 1'b0;
    logic       sel_n_i = 1'b1;

    int  errors = 0;
    int  checks = 0;
    int  rises = 0;
    bit  finished = 1'b0;
    logic [7:0] slv_tx = '0;
    logic [7:0] slv_rx = '0;

    always #4 clk = ~clk;

    assign miso_i = slv_tx[7];

    // bench-side slave for master transfers
    always @(posedge sclk_o) begin
        slv_rx = {slv_rx[6:0], mosi_o};
        rises++;
    end
    always @(negedge sclk_o) slv_tx = {slv_tx[6:0], 1'b0};

    spi_fault_ctrl i_spi_fault_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_sel  (reg_sel),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .sclk_o   (sclk_o),
        .mosi_o   (mosi_o),
        .miso_i   (miso_i),
        .sclk_i   (sclk_i),
        .mosi_i   (mosi_i),
        .sel_n_i  (sel_n_i),
        .miso_o   (miso_o)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // looks at status without a read strobe, so nothing is armed
    task automatic peek_stat(output logic [7:0] v);
        reg_sel = SEL_STAT;
        #1 v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        reg_sel = SEL_STAT;
        #1;
        while (reg_rdata[7] !== 1'b1 && cyc < 5000) begin
            @(negedge clk); #1; cyc++;
        end
    endtask

    task automatic master_byte(input logic [2:0] rate, input logic [7:0] tx, input logic [7:0] sv);
        logic [7:0] v;
        int cyc;
        wr_reg(SEL_CTRL, 8'h50 | {5'd0, rate});
        slv_tx = sv; slv_rx = '0;
        wr_reg(SEL_DATA, tx);
        peek_stat(v);
        chk("R5 done flag low in flight", {31'd0, v[7]}, 32'd0);
        wait_done(cyc);
        chk("R2 byte duration", cyc, 32'd16 << rate);
        chk("R4 master shifted byte", {24'd0, slv_rx}, {24'd0, tx});
        rd_reg(SEL_STAT, v);
        chk("R5 R11 status after byte", {24'd0, v}, 32'h80);
        rd_reg(SEL_DATA, v);
        chk("R4 master received byte", {24'd0, v}, {24'd0, sv});
    endtask

    task automatic slave_byte(input logic [7:0] mb, input logic [7:0] st);
        logic [7:0] v;
        logic [7:0] got;
        got = '0;
        wr_reg(SEL_CTRL, 8'h41);
        wr_reg(SEL_DATA, st);
        sel_n_i = 1'b0;
        idle(4);
        for (int b = 7; b >= 0; b--) begin
            mosi_i = mb[b];
            idle(4);
            got[b] = miso_o;
            sclk_i = 1'b1;
            idle(4);
            sclk_i = 1'b0;
            idle(4);
        end
        peek_stat(v);
        chk("R9 slave done flag", {24'd0, v}, 32'h80);
        sel_n_i = 1'b1;
        idle(4);
        chk("R9 slave presented byte", {24'd0, got}, {24'd0, st});
        rd_reg(SEL_STAT, v);
        chk("R9 status after slave byte", {24'd0, v}, 32'h80);
        rd_reg(SEL_DATA, v);
        chk("R9 slave received byte", {24'd0, v}, {24'd0, mb});
    endtask

    initial begin
        logic [7:0] v;
        int cyc;
        int r0;

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset values
        rd_reg(SEL_CTRL, v);
        chk("R1 control reset", {24'd0, v}, 32'h14);
        rd_reg(SEL_STAT, v);
        chk("R1 status reset", {24'd0, v}, 32'h00);
        rd_reg(SEL_DATA, v);
        chk("R1 data reset", {24'd0, v}, 32'h00);
        chk("R1 sclk idle", {31'd0, sclk_o}, 32'd0);

        // R2 R4 R5 every valid rate
        for (int r = 1; r <= 6; r++) begin
            logic [7:0] tx;
            tx = 8'(r * 8'h29 + 8'h5A);
            master_byte(3'(r), tx, ~{tx[3:0], tx[7:4]});
        end
        // R4 pattern run at the fastest rate
        for (int i = 0; i < 16; i++) begin
            logic [7:0] tx;
            tx = 8'(i * 8'h11) ^ 8'h96;
            master_byte(3'd1, tx, {tx[0], tx[1], tx[2], tx[3], tx[4], tx[5], tx[6], tx[7]} ^ 8'h3C);
        end

        // R3 invalid rate codes
        for (int k = 0; k < 2; k++) begin
            logic [2:0] bad;
            bad = (k == 0) ? 3'd0 : 3'd7;
            wr_reg(SEL_CTRL, 8'h50 | {5'd0, bad});
            rises = 0;
            wr_reg(SEL_DATA, 8'hA5);
            idle(300);
            chk("R3 no clock on invalid code", rises, 32'd0);
            peek_stat(v);
            chk("R3 no done on invalid code", {24'd0, v}, 32'h00);
        end

        // R6 collision, then R7 clearing
        wr_reg(SEL_CTRL, 8'h53);
        slv_tx = 8'h5A; slv_rx = '0;
        wr_reg(SEL_DATA, 8'hC3);
        idle(30);
        wr_reg(SEL_DATA, 8'h0F);
        wait_done(cyc);
        chk("R6 byte in flight unchanged", {24'd0, slv_rx}, 32'hC3);
        rd_reg(SEL_STAT, v);
        chk("R6 collision flag", {24'd0, v}, 32'hC0);
        rd_reg(SEL_DATA, v);
        chk("R6 received byte", {24'd0, v}, 32'h5A);
        peek_stat(v);
        chk("R7 flags cleared by sequence", {24'd0, v}, 32'h00);

        // R7 data access without a prior status read
        wr_reg(SEL_CTRL, 8'h51);
        slv_tx = 8'h00;
        wr_reg(SEL_DATA, 8'h6E);
        idle(80);
        rd_reg(SEL_DATA, v);
        peek_stat(v);
        chk("R7 unarmed data read keeps flag", {24'd0, v}, 32'h80);
        rd_reg(SEL_STAT, v);
        rd_reg(SEL_DATA, v);
        peek_stat(v);
        chk("R7 armed data read clears", {24'd0, v}, 32'h00);

        // R8 mode fault during a master byte
        wr_reg(SEL_CTRL, 8'h56);
        rises = 0;
        wr_reg(SEL_DATA, 8'h99);
        idle(50);
        sel_n_i = 1'b0;
        idle(6);
        sel_n_i = 1'b1;
        chk("R8 clock low after fault", {31'd0, sclk_o}, 32'd0);
        peek_stat(v);
        chk("R8 fault flag", {24'd0, v}, 32'h10);
        rd_reg(SEL_CTRL, v);
        chk("R8 master bit cleared", {24'd0, v}, 32'h46);
        idle(2200);
        chk("R8 byte abandoned", rises, 32'd0);
        peek_stat(v);
        chk("R8 no done after fault", {24'd0, v}, 32'h10);
        rd_reg(SEL_STAT, v);
        rd_reg(SEL_DATA, v);
        peek_stat(v);
        chk("R7 fault flag cleared by sequence", {24'd0, v}, 32'h00);

        // R9 slave bytes
        slave_byte(8'hA5, 8'h3C);
        slave_byte(8'h01, 8'h80);
        slave_byte(8'hFE, 8'h7F);
        slave_byte(8'h69, 8'hD2);
        slave_byte(8'h00, 8'hFF);
        slave_byte(8'hC4, 8'h1B);

        // R10 early release of select
        wr_reg(SEL_CTRL, 8'h41);
        sel_n_i = 1'b0;
        idle(4);
        for (int b = 0; b < 3; b++) begin
            mosi_i = b[0];
            idle(4); sclk_i = 1'b1;
            idle(4); sclk_i = 1'b0;
            idle(4);
        end
        sel_n_i = 1'b1;
        idle(6);
        peek_stat(v);
        chk("R10 abort flag set", {24'd0, v}, 32'h20);
        rd_reg(SEL_STAT, v);
        rd_reg(SEL_DATA, v);
        peek_stat(v);
        chk("R10 abort survives clearing sequence", {24'd0, v}, 32'h20);
        chk("R11 reserved status bits", {28'd0, v[3:0]}, 32'd0);
        wr_reg(SEL_CTRL, 8'h01);
        idle(1);
        peek_stat(v);
        chk("R10 disable clears abort", {24'd0, v}, 32'h00);

        // R12 disable in mid-byte
        wr_reg(SEL_CTRL, 8'h55);
        wr_reg(SEL_DATA, 8'h3C);
        idle(100);
        wr_reg(SEL_CTRL, 8'h15);
        idle(2);
        chk("R12 clock low after disable", {31'd0, sclk_o}, 32'd0);
        r0 = rises;
        idle(700);
        chk("R12 no further clock", rises, r0);
        peek_stat(v);
        chk("R12 no done after disable", {24'd0, v}, 32'h00);

        // recovery after disable
        master_byte(3'd2, 8'hB7, 8'h4D);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule